// File: doc/BRIEF.md
# Hybrid Rule 90/150 Cellular Automaton Register

This block is a one-dimensional linear cellular automaton register of `WIDTH` cells. Each cell holds one flip-flop. Its next value comes only from XOR logic over its immediate neighbours and, depending on a compile-time rule vector, its own value. No connection spans more than one cell position.

The register has two modes. In pattern mode it steps on its own and produces pseudo-random test vectors on `ca_state`. In compaction mode it folds response data into a signature. That data can arrive on two serial bits, one at each end of the array, and on a parallel word with one bit per cell.

The compaction data interface is a valid/ready stream. `cmp_ready` is high only while compaction mode is selected, `step_en` is high and no load is pending. A beat is consumed when `cmp_valid` and `cmp_ready` are both high on a rising edge. When the consumer deasserts readiness, the producer must hold its data. The register never stores a beat it has not accepted.

Top module: `ca_hybrid_reg`

## Requirements
- R1: While `rst_n` is low, the register is set to `SEED_DEFAULT`, a nonzero parameter.
- R2: A cell whose bit in `RULE_VEC` is 1 (rule 150) takes the XOR of its left neighbour, itself and its right neighbour when it steps.
- R3: A cell whose bit in `RULE_VEC` is 0 (rule 90) takes the XOR of its two neighbours only when it steps. Cell i's neighbours are cells i-1 and i+1.
- R4: The missing neighbour of cell 0 and of cell `WIDTH-1` reads as zero.
- R5: In pattern mode (`ca_mode`=0), the register steps on every edge where `step_en` is 1. It holds its value when `step_en` is 0 and `seed_load` is 0.
- R6: `seed_load`=1 has priority over stepping and writes `seed_val` into the register when `seed_val` is nonzero.
- R7: A zero `seed_val` loaded in pattern mode is replaced by `SEED_DEFAULT`. A zero `seed_val` loaded in compaction mode (`ca_mode`=1) is stored as zero.
- R8: In compaction mode, an accepted beat XORs bit i of `cmp_par` into cell i's rule result, for every cell.
- R9: In compaction mode, an accepted beat XORs `cmp_ser_lo` into cell 0's result and `cmp_ser_hi` into cell `WIDTH-1`'s result.
- R10: `cmp_ready` equals `ca_mode` & `step_en` & !`seed_load`. In compaction mode without an accepted beat, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ca_mode | input | 1 | 0 = pattern generation, 1 = compaction |
| step_en | input | 1 | Step enable |
| seed_load | input | 1 | Load `seed_val` this edge |
| seed_val | input | WIDTH | Seed value |
| cmp_valid | input | 1 | Compaction beat valid |
| cmp_ready | output | 1 | Compaction beat ready |
| cmp_ser_lo | input | 1 | Serial bit injected at cell 0 |
| cmp_ser_hi | input | 1 | Serial bit injected at cell WIDTH-1 |
| cmp_par | input | WIDTH | Parallel word, bit i into cell i |
| ca_state | output | WIDTH | Register contents |

## Verification
The assertions take for granted that `ca_mode`, `step_en`, `seed_load` and `cmp_valid` are known, and change only between clock edges once reset has been released. They also assume that a producer holds a beat while `cmp_ready` is low. The stimulus drives every input on the falling edge. It switches modes only between complete phases. It offers compaction beats with `cmp_valid` toggling, which exercises both accepted and refused beats without ever changing the data of a beat that is being refused.

// File: rtl/ca_pkg.sv
package ca_pkg;
  typedef enum logic {
    MODE_GEN     = 1'b0,
    MODE_COMPACT = 1'b1
  } ca_mode_e;
endpackage

// File: rtl/ca_rule_array.sv
module ca_rule_array #(
  parameter int          WIDTH    = 16,
  parameter logic [WIDTH-1:0] RULE_VEC = '0
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] inject,
  output logic [WIDTH-1:0] nxt
);
  localparam int LAST = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic nb_lo, nb_hi, self_term;
    if (i == 0) begin : g_lo_edge
      assign nb_lo = 1'b0;
    end else begin : g_lo_in
      assign nb_lo = cur[i-1];
    end
    if (i == LAST) begin : g_hi_edge
      assign nb_hi = 1'b0;
    end else begin : g_hi_in
      assign nb_hi = cur[i+1];
    end
    if (RULE_VEC[i]) begin : g_r150
      assign self_term = cur[i];
    end else begin : g_r90
      assign self_term = 1'b0;
    end
    assign nxt[i] = nb_lo ^ nb_hi ^ self_term ^ inject[i];
  end
endmodule

// File: rtl/ca_inject_mux.sv
module ca_inject_mux #(
  parameter int WIDTH = 16
) (
  input  logic             compact_en,
  input  logic [WIDTH-1:0] par,
  input  logic             ser_lo,
  input  logic             ser_hi,
  output logic [WIDTH-1:0] inject
);
  logic [WIDTH-1:0] ser_vec;

  always_comb begin
    ser_vec            = '0;
    ser_vec[0]         = ser_lo;
    ser_vec[WIDTH-1]   = ser_vec[WIDTH-1] ^ ser_hi;
    inject             = compact_en ? (par ^ ser_vec) : '0;
  end
endmodule

// File: rtl/ca_seed_ctl.sv
module ca_seed_ctl #(
  parameter int               WIDTH        = 16,
  parameter logic [WIDTH-1:0] SEED_DEFAULT = 1
) (
  input  logic             gen_mode,
  input  logic [WIDTH-1:0] seed_in,
  output logic [WIDTH-1:0] seed_out
);
  logic seed_zero;
  assign seed_zero = (seed_in == '0);
  assign seed_out  = (seed_zero && gen_mode) ? SEED_DEFAULT : seed_in;
endmodule

// File: rtl/ca_hybrid_reg.sv
module ca_hybrid_reg #(
  parameter int               WIDTH        = 16,
  parameter logic [WIDTH-1:0] RULE_VEC     = 16'h6A5C,
  parameter logic [WIDTH-1:0] SEED_DEFAULT = 16'h0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ca_mode,
  input  logic             step_en,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed_val,
  input  logic             cmp_valid,
  output logic             cmp_ready,
  input  logic             cmp_ser_lo,
  input  logic             cmp_ser_hi,
  input  logic [WIDTH-1:0] cmp_par,
  output logic [WIDTH-1:0] ca_state
);
  import ca_pkg::*;

  ca_mode_e         mode_q;
  logic [WIDTH-1:0] state_q, step_val, inject, load_val;
  logic             is_compact, gen_step, cmp_fire;

  assign mode_q     = ca_mode_e'(ca_mode);
  assign is_compact = (mode_q == MODE_COMPACT);
  assign cmp_ready  = is_compact && step_en && !seed_load;
  assign cmp_fire   = cmp_ready && cmp_valid;
  assign gen_step   = !is_compact && step_en && !seed_load;

  ca_inject_mux #(.WIDTH(WIDTH)) u_inject (
    .compact_en (is_compact),
    .par        (cmp_par),
    .ser_lo     (cmp_ser_lo),
    .ser_hi     (cmp_ser_hi),
    .inject     (inject)
  );

  ca_rule_array #(.WIDTH(WIDTH), .RULE_VEC(RULE_VEC)) u_rules (
    .cur    (state_q),
    .inject (inject),
    .nxt    (step_val)
  );

  ca_seed_ctl #(.WIDTH(WIDTH), .SEED_DEFAULT(SEED_DEFAULT)) u_seed (
    .gen_mode (!is_compact),
    .seed_in  (seed_val),
    .seed_out (load_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                    state_q <= SEED_DEFAULT;
    else if (seed_load)            state_q <= load_val;
    else if (gen_step || cmp_fire) state_q <= step_val;
  end

  assign ca_state = state_q;
endmodule

// File: rtl/ca_hybrid_reg_chk.sv
module ca_hybrid_reg_chk #(
  parameter int               WIDTH        = 16,
  parameter logic [WIDTH-1:0] SEED_DEFAULT = 16'h0001
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ca_mode,
  input logic             step_en,
  input logic             seed_load,
  input logic [WIDTH-1:0] seed_val,
  input logic             cmp_valid,
  input logic             cmp_ready,
  input logic [WIDTH-1:0] ca_state
);
  AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ca_mode && !step_en && !seed_load) |=> $stable(ca_state)); // R5
  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && seed_val != '0) |=> (ca_state == $past(seed_val))); // R6
  AST_ZERO_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && seed_val == '0 && !ca_mode) |=> (ca_state == SEED_DEFAULT)); // R7
  AST_ZERO_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && seed_val == '0 && ca_mode) |=> (ca_state == '0)); // R7
  AST_CMP_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ca_mode && !seed_load && !(cmp_valid && cmp_ready)) |=> $stable(ca_state)); // R10
  AST_READY_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |-> !cmp_ready); // R10
endmodule

bind ca_hybrid_reg ca_hybrid_reg_chk #(.WIDTH(WIDTH), .SEED_DEFAULT(SEED_DEFAULT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ca_mode   (ca_mode),
  .step_en   (step_en),
  .seed_load (seed_load),
  .seed_val  (seed_val),
  .cmp_valid (cmp_valid),
  .cmp_ready (cmp_ready),
  .ca_state  (ca_state)
);

// File: tb/ca_hybrid_reg_tb.sv
`timescale 1ns/1ps
module ca_hybrid_reg_tb;
  localparam int          W    = 16;
  localparam logic [W-1:0] RV  = 16'h6A5C;
  localparam logic [W-1:0] DEF = 16'h0001;

  logic clk = 0, rst_n = 0;
  logic ca_mode = 0, step_en = 0, seed_load = 0, cmp_valid = 0;
  logic cmp_ser_lo = 0, cmp_ser_hi = 0;
  logic [W-1:0] seed_val = '0, cmp_par = '0;
  logic cmp_ready;
  logic [W-1:0] ca_state;
  logic [W-1:0] model;
  int checks = 0, failures = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  ca_hybrid_reg #(.WIDTH(W), .RULE_VEC(RV), .SEED_DEFAULT(DEF)) u_dut (
    .clk(clk), .rst_n(rst_n), .ca_mode(ca_mode), .step_en(step_en),
    .seed_load(seed_load), .seed_val(seed_val), .cmp_valid(cmp_valid),
    .cmp_ready(cmp_ready), .cmp_ser_lo(cmp_ser_lo), .cmp_ser_hi(cmp_ser_hi),
    .cmp_par(cmp_par), .ca_state(ca_state)
  );

  function automatic logic [W-1:0] ca_next(logic [W-1:0] s, logic [W-1:0] par,
                                           logic lo, logic hi);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      logic a, b;
      a = (i > 0) ? s[i-1] : 1'b0;
      b = (i < W-1) ? s[i+1] : 1'b0;
      r[i] = a ^ b ^ (RV[i] ? s[i] : 1'b0) ^ par[i];
    end
    r[0]   = r[0] ^ lo;
    r[W-1] = r[W-1] ^ hi;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) model <= DEF;
    else if (seed_load) model <= (seed_val == '0 && !ca_mode) ? DEF : seed_val;
    else if (step_en && !ca_mode) model <= ca_next(model, '0, 1'b0, 1'b0);
    else if (step_en && ca_mode && cmp_valid)
      model <= ca_next(model, cmp_par, cmp_ser_lo, cmp_ser_hi);
  end

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference model, away from the edge
  always @(negedge clk) if (rst_n) begin
    check(tag, ca_state, model);
    check("R10", {15'd0, cmp_ready}, {15'd0, ca_mode & step_en & ~seed_load});
  end

  task automatic load(logic [W-1:0] v, logic m);
    @(negedge clk);
    ca_mode = m; seed_load = 1; seed_val = v; step_en = 1;
    @(negedge clk);
    seed_load = 0; step_en = 0;
  endtask

  task automatic gen_steps(int n);
    @(negedge clk); ca_mode = 0; step_en = 1;
    repeat (n) @(negedge clk);
    step_en = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", ca_state, DEF);
    @(negedge clk); rst_n = 1;

    // R2 / R3: single set cell in the middle spreads to its neighbours
    tag = "R2";
    load(16'h0100, 0);
    check("R6", ca_state, 16'h0100);
    gen_steps(1);
    check("R3", ca_state, 16'h0280 | (RV[8] ? 16'h0100 : 16'h0000));
    load(16'h0040, 0);
    gen_steps(1);
    check("R2", ca_state, 16'h00A0 | (RV[6] ? 16'h0040 : 16'h0000));

    // R4: end cells see zero beyond the array
    tag = "R4";
    load(16'h0001, 0);
    gen_steps(1);
    check("R4", ca_state, 16'h0002 | (RV[0] ? 16'h0001 : 16'h0000));
    load(16'h8000, 0);
    gen_steps(1);
    check("R4", ca_state, 16'h4000 | (RV[15] ? 16'h8000 : 16'h0000));

    // R5: free run, then hold
    tag = "R5";
    load(16'hBEEF, 0);
    gen_steps(40);
    repeat (5) @(negedge clk);

    // R7: zero seed handling per mode
    tag = "R7";
    load(16'h0000, 0);
    check("R7", ca_state, DEF);
    load(16'h0000, 1);
    check("R7", ca_state, 16'h0000);

    // R8 / R9 / R10: compaction with toggling valid
    tag = "R8";
    @(negedge clk); ca_mode = 1; step_en = 1;
    cmp_par = 16'h1234; cmp_valid = 1;
    @(negedge clk);
    check("R8", ca_state, 16'h1234);
    cmp_valid = 0;
    @(negedge clk);
    tag = "R9";
    for (int k = 0; k < 60; k++) begin
      cmp_par    = W'(k * 16'h9E37 + 16'h51);
      cmp_ser_lo = k[0];
      cmp_ser_hi = k[1] ^ k[2];
      cmp_valid  = (k % 3) != 2;
      @(negedge clk);
    end
    cmp_valid = 0; cmp_par = '0;
    load(16'h0000, 1);
    @(negedge clk); step_en = 1; cmp_ser_lo = 1; cmp_ser_hi = 1; cmp_valid = 1;
    @(negedge clk);
    check("R9", ca_state, 16'h8001);
    cmp_valid = 0; cmp_ser_lo = 0; cmp_ser_hi = 0;
    tag = "R10";
    step_en = 0; cmp_valid = 1;
    repeat (3) @(negedge clk);
    check("R10", ca_state, 16'h8001);
    cmp_valid = 0;

    // R1: reset in mid-run
    tag = "R1";
    rst_n = 0;
    @(negedge clk);
    check("R1", ca_state, DEF);
    rst_n = 1;
    gen_steps(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule